// File: doc/BRIEF.md
# Bus-Attached Multiply-Accumulate Unit

This block is a multiplier peripheral that sits on a CPU's register bus rather than inside the processor pipeline. Software loads a first operand and a second operand into two 16-bit registers. It then reads a 32-bit result as a low word and a high word, plus a 16-bit extension word. The extension word reports the sign of a signed result or the carry out of an unsigned accumulation. There is no separate mode register. The bus address used to write the first operand selects one of four operations: unsigned multiply, signed multiply, unsigned multiply-accumulate or signed multiply-accumulate.

Writing the second operand launches the operation. The block raises a wait output for exactly one clock, which holds the CPU. The result registers update at the end of that clock. In the accumulate modes the product is added to the current contents of the two result words, so those words act as the accumulator. Software can write them directly to preload a starting value.

Byte writes to an operand register give 8-bit operands. In signed modes the byte is sign-extended and in unsigned modes it is zero-extended, so 16x16, 16x8, 8x16 and 8x8 products all use the same datapath.

Top module: `mul_periph`

## Requirements
- R1: After reset every register reads 0x0000 and the wait output is low.
- R2: The operand-1 address fixes the operation: 0x10 unsigned multiply, 0x12 signed multiply, 0x14 unsigned accumulate, 0x16 signed accumulate. The mode is held until the next operand-1 write. An operand-1 write by itself leaves the result words unchanged.
- R3: A write to the operand-2 address 0x18 starts the operation. The wait output is high during the clock after that write and low in the clock after that, when the new result is readable.
- R4: Unsigned multiply puts the 32-bit unsigned product in the result low word (0x1A) and high word (0x1C), and the extension word (0x1E) reads 0x0000.
- R5: Signed multiply puts the two's-complement product in the result words. The extension word reads 0xFFFF when the product is negative and 0x0000 otherwise.
- R6: Unsigned accumulate adds the unsigned product to the 32-bit {high, low} result. The extension word reads 0x0001 when that sum carries out of 32 bits and 0x0000 otherwise.
- R7: Signed accumulate adds the signed product to the {high, low} result, wrapping modulo 2^32. The extension word is 0xFFFF when bit 31 of the new result is set and 0x0000 otherwise.
- R8: A byte write (wdata bits 7:0 only) to an operand register sign-extends from bit 7 in signed modes and zero-extends in unsigned modes. For operand 1 the mode is the one selected by the address being written. For operand 2 it is the latched mode.
- R9: The three result registers can be written. A word write stores all 16 bits, and a byte write stores bits 7:0 zero-extended. The written value then serves as the accumulator.
- R10: Operand 1 reads back from any of 0x10, 0x12, 0x14 and 0x16, and operand 2 reads back from 0x18.
- R11: Bus writes issued while the wait output is high are ignored.
- R12: Addresses below 0x10 and odd addresses read 0x0000, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte write using wdata bits 7:0 |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for bus_addr |
| bus_wait | output | 1 | CPU hold, high for one clock after an operand-2 write |

## Verification
Each of the four modes is swept over a grid of boundary operands: zero, one, 0x7F, 0x80, 0xFF, 0x7FFF, 0x8000, 0xFFFF and two mixed values. This grid separates signed from unsigned interpretation and exposes sign errors in the extension word. A second sweep runs a stride-17 grid of byte operands in the 8x8, 8x16 and 16x8 shapes, which tells sign extension apart from zero extension on each operand independently. Accumulate runs chain results without clearing, and a preloaded all-ones accumulator forces the carry out. Together these distinguish a correct carry and wrap from a dropped or sign-confused one.

// File: rtl/mulp_pkg.sv
package mulp_pkg;

  typedef enum logic [1:0] {
    MD_UMUL = 2'd0,
    MD_SMUL = 2'd1,
    MD_UMAC = 2'd2,
    MD_SMAC = 2'd3
  } mode_e;

  // word indices (byte address >> 1)
  localparam int WI_OP1_FIRST = 8;
  localparam int WI_OP1_LAST  = 11;
  localparam int WI_OP2       = 12;
  localparam int WI_RLO       = 13;
  localparam int WI_RHI       = 14;
  localparam int WI_REXT      = 15;

  function automatic logic mode_signed(mode_e m);
    return (m == MD_SMUL) || (m == MD_SMAC);
  endfunction

endpackage

// File: rtl/mulp_rst_sync.sv
module mulp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mulp_extend.sv
module mulp_extend #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic              byte_i,
  input  logic              sgn_i,
  output logic [DATA_W-1:0] val_o
);
  localparam int PAD_W = DATA_W - BYTE_W;

  always_comb begin
    if (!byte_i)
      val_o = raw_i;
    else if (sgn_i)
      val_o = {{PAD_W{raw_i[BYTE_W-1]}}, raw_i[BYTE_W-1:0]};
    else
      val_o = {{PAD_W{1'b0}}, raw_i[BYTE_W-1:0]};
  end
endmodule

// File: rtl/mulp_datapath.sv
module mulp_datapath
  import mulp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]   op1_i,
  input  logic [DATA_W-1:0]   op2_i,
  input  mode_e               mode_i,
  input  logic [2*DATA_W-1:0] acc_i,
  output logic [2*DATA_W-1:0] res_o,
  output logic [DATA_W-1:0]   ext_o
);
  localparam int PROD_W = 2 * DATA_W;

  logic        [PROD_W-1:0] prod_u;
  logic signed [PROD_W-1:0] prod_s;
  logic        [PROD_W:0]   sum_u;
  logic        [PROD_W-1:0] sum_s;

  assign prod_u = PROD_W'(op1_i) * PROD_W'(op2_i);
  assign prod_s = PROD_W'($signed(op1_i)) * PROD_W'($signed(op2_i));
  assign sum_u  = {1'b0, acc_i} + {1'b0, prod_u};
  assign sum_s  = acc_i + prod_s;

  always_comb begin
    unique case (mode_i)
      MD_UMUL: begin
        res_o = prod_u;
        ext_o = '0;
      end
      MD_SMUL: begin
        res_o = prod_s;
        ext_o = {DATA_W{prod_s[PROD_W-1]}};
      end
      MD_UMAC: begin
        res_o = sum_u[PROD_W-1:0];
        ext_o = DATA_W'(sum_u[PROD_W]);
      end
      default: begin
        res_o = sum_s;
        ext_o = {DATA_W{sum_s[PROD_W-1]}};
      end
    endcase
  end
endmodule

// File: rtl/mul_periph.sv
module mul_periph
  import mulp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int PROD_W = 2 * DATA_W;
  localparam int WORD_W = ADDR_W - 1;

  logic rst_n_i;
  mulp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  // state
  logic [DATA_W-1:0] op1_q, op2_q, lo_q, hi_q, ext_q;
  mode_e             mode_q;
  logic              busy_q;
  // next state
  logic [DATA_W-1:0] op1_d, op2_d, lo_d, hi_d, ext_d;
  mode_e             mode_d;
  logic              busy_d;

  // decode
  logic [WORD_W-1:0] word;
  logic              aligned, wr_ok, hit_op1, hit_op2;
  mode_e             addr_mode;
  logic [DATA_W-1:0] op1_wval, op2_wval, plain_wval;

  assign word      = bus_addr[ADDR_W-1:1];
  assign aligned   = ~bus_addr[0];
  assign wr_ok     = bus_sel & bus_wr & aligned & ~busy_q;
  assign hit_op1   = (int'(word) >= WI_OP1_FIRST) && (int'(word) <= WI_OP1_LAST);
  assign hit_op2   = (int'(word) == WI_OP2);
  assign addr_mode = mode_e'(word[1:0]);

  mulp_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext1 (
    .raw_i(bus_wdata), .byte_i(bus_byte), .sgn_i(mode_signed(addr_mode)), .val_o(op1_wval));
  mulp_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext2 (
    .raw_i(bus_wdata), .byte_i(bus_byte), .sgn_i(mode_signed(mode_q)), .val_o(op2_wval));
  mulp_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_extr (
    .raw_i(bus_wdata), .byte_i(bus_byte), .sgn_i(1'b0), .val_o(plain_wval));

  logic [PROD_W-1:0] dp_res;
  logic [DATA_W-1:0] dp_ext;

  mulp_datapath #(.DATA_W(DATA_W)) u_dp (
    .op1_i(op1_q), .op2_i(op2_q), .mode_i(mode_q),
    .acc_i({hi_q, lo_q}), .res_o(dp_res), .ext_o(dp_ext));

  // next-state logic
  always_comb begin
    op1_d  = op1_q;
    op2_d  = op2_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    ext_d  = ext_q;
    mode_d = mode_q;
    busy_d = 1'b0;
    if (busy_q) begin
      {hi_d, lo_d} = dp_res;
      ext_d        = dp_ext;
    end else if (wr_ok) begin
      if (hit_op1) begin
        op1_d  = op1_wval;
        mode_d = addr_mode;
      end else if (hit_op2) begin
        op2_d  = op2_wval;
        busy_d = 1'b1;
      end else if (int'(word) == WI_RLO) begin
        lo_d = plain_wval;
      end else if (int'(word) == WI_RHI) begin
        hi_d = plain_wval;
      end else if (int'(word) == WI_REXT) begin
        ext_d = plain_wval;
      end
    end
  end

  logic reg_en;
  assign reg_en = busy_q | wr_ok;

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      op1_q  <= '0;
      op2_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      ext_q  <= '0;
      mode_q <= MD_UMUL;
      busy_q <= 1'b0;
    end else if (reg_en) begin
      op1_q  <= op1_d;
      op2_q  <= op2_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      ext_q  <= ext_d;
      mode_q <= mode_d;
      busy_q <= busy_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (hit_op1)                     bus_rdata = op1_q;
      else if (hit_op2)                bus_rdata = op2_q;
      else if (int'(word) == WI_RLO)   bus_rdata = lo_q;
      else if (int'(word) == WI_RHI)   bus_rdata = hi_q;
      else if (int'(word) == WI_REXT)  bus_rdata = ext_q;
    end
  end

  assign bus_wait = busy_q;

  // assertions
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_ok && hit_op2) |=> bus_wait);
  p_wait_one_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_wait |=> !bus_wait);
  p_op1_only_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_ok && hit_op1) |=> ($stable(lo_q) && $stable(hi_q) && $stable(ext_q) && !bus_wait));
  p_umul_ext_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy_q && mode_q == MD_UMUL) |=> (ext_q == '0));
  p_smul_ext_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy_q && mode_q == MD_SMUL) |=> (ext_q == {DATA_W{hi_q[DATA_W-1]}}));
  p_umac_ext_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy_q && mode_q == MD_UMAC) |=> (ext_q[DATA_W-1:1] == '0));
  p_smac_ext_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy_q && mode_q == MD_SMAC) |=> (ext_q == {DATA_W{hi_q[DATA_W-1]}}));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    busy_q |=> ($stable(op1_q) && $stable(op2_q) && $stable(mode_q)));

endmodule

// File: tb/sim_mul_periph.sv
`timescale 1ns/1ps
module sim_mul_periph;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_byte;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_wait;

  int checks = 0;
  int failures = 0;
  logic [31:0] acc_m;  // bench model of {hi, lo}

  mul_periph u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_wait(bus_wait));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic byt);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_byte = byt;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [15:0] eff(input logic [15:0] v, input logic byt, input int md);
    if (!byt) return v;
    if (md == 1 || md == 3) return {{8{v[7]}}, v[7:0]};
    return {8'h00, v[7:0]};
  endfunction

  function automatic logic [47:0] model(input int md, input logic [15:0] a, input logic [15:0] b,
                                        input logic [31:0] acc);
    logic [63:0] pu, ps, s;
    pu = 64'(a) * 64'(b);
    ps = 64'(longint'($signed(a)) * longint'($signed(b)));
    case (md)
      0: return {16'h0000, pu[31:0]};
      1: return {(ps[63] ? 16'hFFFF : 16'h0000), ps[31:0]};
      2: begin
        s = 64'(acc) + pu;
        return {15'd0, s[32], s[31:0]};
      end
      default: begin
        s = 64'(acc) + ps;
        return {(s[31] ? 16'hFFFF : 16'h0000), s[31:0]};
      end
    endcase
  endfunction

  // one full operation; checks hold timing and all three result words
  task automatic run_op(input int md, input logic [15:0] a, input logic byta,
                        input logic [15:0] b, input logic bytb, input string req);
    logic [15:0] ea, eb, lo, hi, ex;
    logic [47:0] e;
    ea = eff(a, byta, md);
    eb = eff(b, bytb, md);
    e  = model(md, ea, eb, acc_m);
    wr(5'(8'h10 + 2 * md), a, byta);
    wr(5'h18, b, bytb);
    chk(bus_wait === 1'b1, "R3 wait high after start", 64'(bus_wait), 64'd1);
    @(negedge clk);
    chk(bus_wait === 1'b0, "R3 wait released", 64'(bus_wait), 64'd0);
    rd(5'h1A, lo); rd(5'h1C, hi); rd(5'h1E, ex);
    chk({ex, hi, lo} === e, req, 64'({ex, hi, lo}), 64'(e));
    acc_m = e[31:0];
  endtask

  initial begin
    logic [15:0] d, lo, hi, ex;
    logic [15:0] pats [10];
    pats[0] = 16'h0000; pats[1] = 16'h0001; pats[2] = 16'h007F; pats[3] = 16'h0080;
    pats[4] = 16'h00FF; pats[5] = 16'h7FFF; pats[6] = 16'h8000; pats[7] = 16'hFFFF;
    pats[8] = 16'h1234; pats[9] = 16'hABCD;

    bus_sel = 0; bus_wr = 0; bus_byte = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    acc_m = '0;

    // R1 reset state
    for (int k = 0; k < 8; k++) begin
      rd(5'(8'h10 + 2 * k), d);
      chk(d === 16'h0000, "R1 reset value", 64'(d), 64'd0);
    end
    chk(bus_wait === 1'b0, "R1 wait low", 64'(bus_wait), 64'd0);

    // R9 result preload, R2 operand-1 write leaves results
    wr(5'h1A, 16'hAB55, 1'b1); rd(5'h1A, d);
    chk(d === 16'h0055, "R9 byte write result low", 64'(d), 64'h55);
    wr(5'h1C, 16'hBEEF, 1'b0); rd(5'h1C, d);
    chk(d === 16'hBEEF, "R9 word write result high", 64'(d), 64'hBEEF);
    wr(5'h1E, 16'h1357, 1'b0); rd(5'h1E, d);
    chk(d === 16'h1357, "R9 write extension", 64'(d), 64'h1357);
    wr(5'h14, 16'h4321, 1'b0);
    chk(bus_wait === 1'b0, "R2 no start on operand 1", 64'(bus_wait), 64'd0);
    rd(5'h1A, lo); rd(5'h1C, hi); rd(5'h1E, ex);
    chk({ex, hi, lo} === 48'h1357_BEEF_0055, "R2 results unchanged", 64'({ex, hi, lo}), 64'h1357BEEF0055);

    // R10 read-back aliases
    for (int k = 0; k < 4; k++) begin
      rd(5'(8'h10 + 2 * k), d);
      chk(d === 16'h4321, "R10 operand 1 alias", 64'(d), 64'h4321);
    end

    // R8 byte extension
    wr(5'h12, 16'h3380, 1'b1); rd(5'h10, d);
    chk(d === 16'hFF80, "R8 op1 signed byte", 64'(d), 64'hFF80);
    wr(5'h18, 16'h44FE, 1'b1); @(negedge clk); rd(5'h18, d);
    chk(d === 16'hFFFE, "R8 op2 signed byte via latched mode", 64'(d), 64'hFFFE);
    rd(5'h1A, lo); rd(5'h1C, hi);
    chk({hi, lo} === 32'h0000_0100, "R5 byte signed product", 64'({hi, lo}), 64'h100);
    wr(5'h14, 16'h3380, 1'b1); rd(5'h16, d);
    chk(d === 16'h0080, "R8 op1 unsigned byte", 64'(d), 64'h80);

    // R12 undecoded and odd addresses
    wr(5'h1B, 16'h9999, 1'b0); rd(5'h1B, d);
    chk(d === 16'h0000, "R12 odd address reads zero", 64'(d), 64'd0);
    wr(5'h04, 16'h7777, 1'b0); rd(5'h04, d);
    chk(d === 16'h0000, "R12 low address reads zero", 64'(d), 64'd0);
    rd(5'h1A, lo); rd(5'h1C, hi);
    chk({hi, lo} === 32'h0000_0100, "R12 results untouched", 64'({hi, lo}), 64'h100);
    rd(5'h16, d);
    chk(d === 16'h0080, "R12 operand untouched", 64'(d), 64'h80);

    // R6 carry out and no carry
    wr(5'h1A, 16'hFFFF, 1'b0); wr(5'h1C, 16'hFFFF, 1'b0); acc_m = 32'hFFFF_FFFF;
    run_op(2, 16'h0001, 1'b0, 16'h0001, 1'b0, "R6 carry out");
    rd(5'h1E, d);
    chk(d === 16'h0001, "R6 extension carry", 64'(d), 64'd1);
    run_op(2, 16'h0002, 1'b0, 16'h0003, 1'b0, "R6 no carry");
    rd(5'h1E, d);
    chk(d === 16'h0000, "R6 extension no carry", 64'(d), 64'd0);

    // R11 write during hold ignored
    wr(5'h10, 16'h0010, 1'b0);
    wr(5'h18, 16'h0020, 1'b0);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h1A; bus_wdata = 16'h5A5A;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(5'h1A, d);
    chk(d === 16'h0200, "R11 write during wait ignored", 64'(d), 64'h200);
    acc_m = 32'h0000_0200;

    // sweeps over the boundary grid, every mode, word operands
    for (int md = 0; md < 4; md++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_op(md, pats[i], 1'b0, pats[j], 1'b0,
                 md == 0 ? "R4 umul" : md == 1 ? "R5 smul" : md == 2 ? "R6 umac" : "R7 smac");

    // byte-operand shapes: 8x8, 8x16, 16x8
    for (int sh = 0; sh < 3; sh++)
      for (int md = 0; md < 4; md++)
        for (int i = 0; i < 16; i++)
          for (int j = 0; j < 16; j++)
            run_op(md, 16'(16'hA500 + i * 17), sh != 2, 16'(16'h5A00 + j * 17), sh != 1, "R8 byte shape");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule